// File: doc/BRIEF.md
# Memory-Mapped Local Interrupt Timer

This block is a countdown timer that a processor programs through a small 32-bit register window. It raises one vectored interrupt request. Software writes a start value into the initial-count register, and the block loads that value into a current-count register. The current count then drops by one on every tick of a programmable prescaler. When the count reaches zero, the block sets a pending flag. In periodic mode the count reloads from the initial value and keeps running. In one-shot mode the count stays at zero and the timer stops.

Three gates stand between the pending flag and the request pin: a global software-enable bit, a mask bit in the timer's vector entry, and a task-priority threshold. A pending flag that is blocked by a gate is held, and it is delivered as soon as all gates are open. The acknowledge input clears the flag. Every bus access must assert all four byte enables. Any narrower access is dropped without effect and reads back zero.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset every register reads zero except the vector entry at 0x320, which reads 0x0001_0000 (masked). The unit is disabled and irq_req is low.
- R2: The register offsets are 0x080 priority threshold (bits 7:0), 0x0F0 enable/spurious (bit 8 enable, bits 7:0 spurious vector), 0x320 vector entry (bits 7:0 vector, bit 16 mask, bit 17 periodic), 0x380 initial count (32 bits), 0x390 current count (read-only) and 0x3E0 divide (bits 3, 1 and 0 stored, bit 2 reads 0). Other bits, writes to 0x390 and unmapped offsets all read zero.
- R3: The divide code {bit3,bit1,bit0} selects the prescale ratio D: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1. Bit 2 has no effect. After an initial-count write of N at clock edge E, the pending flag is set at edge E+N·D.
- R4: In one-shot mode (bit 17 = 0) the timer fires once, the current count then reads 0, and no further event occurs.
- R5: In periodic mode (bit 17 = 1) the count reloads, and events recur every N·D cycles measured from the load.
- R6: While enable bit 8 is clear, irq_req stays low. A write that sets only the low byte does not enable the unit. A pending event is delivered once bit 8 is set.
- R7: While the mask bit is 1, irq_req stays low. The pending flag is held and is delivered when the mask is cleared.
- R8: irq_req is blocked while the 8-bit priority threshold is greater than the 8-bit vector. It passes when the threshold is equal to or less than the vector.
- R9: A write with fewer than all four byte enables changes no register. A read with fewer than all four byte enables returns 0.
- R10: A pulse on irq_ack clears the pending flag, and irq_req is low in the following cycle.
- R11: Writing 0 to the initial count stops the timer. The current count then reads 0 and no event follows.
- R12: irq_vec always equals the vector field of the vector entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, read data is combinational |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, all four are required |
| bus_rdata | output | 32 | Read data, zero when no valid read |
| irq_ack | input | 1 | Acknowledge, clears the pending flag |
| irq_req | output | 1 | Gated interrupt request |
| irq_vec | output | 8 | Vector that goes with the request |

## Verification
The countdown is driven with random divide codes (with bit 2 flipped at random) and random start values. A wrong mapping of the ratio table, or a miscount by one in the prescaler or the counter, then shows up as a wrong arrival cycle. A periodic run with several acknowledged events shows whether the reload keeps a fixed interval from the load, or whether it drifts by the cycles taken by the acknowledge. Directed cases hold an event behind each gate in turn: the mask, the enable bit with a low-byte-only write, and a threshold one above the vector versus equal to it. Each case checks that the flag is held rather than lost. Narrow accesses, writes to the read-only count and a zero start value show whether stray accesses leave the state unchanged.

// File: rtl/irqt_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt timer: register offsets, widths and
// the divide-code decoder. Assumes a 32-bit bus with a 12-bit byte offset.
package irqt_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;
    localparam int BE_W   = BUS_W / 8;
    localparam int VEC_W  = 8;
    localparam int CODE_W = 3;
    localparam int PRE_W  = 7;   // holds the largest ratio minus one (127)

    localparam logic [ADDR_W-1:0] OFF_TPR = 12'h080;
    localparam logic [ADDR_W-1:0] OFF_SVR = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFF_LVT = 12'h320;
    localparam logic [ADDR_W-1:0] OFF_ICR = 12'h380;
    localparam logic [ADDR_W-1:0] OFF_CCR = 12'h390;
    localparam logic [ADDR_W-1:0] OFF_DCR = 12'h3E0;

    // Ratio minus one for a divide code: code 7 is divide by 1, otherwise 2^(code+1).
    function automatic logic [PRE_W-1:0] ratio_m1(input logic [CODE_W-1:0] code);
        logic [PRE_W:0] full;
        full = (code == 3'd7) ? '0 : (((PRE_W+1)'(2)) << code) - 1'b1;
        return full[PRE_W-1:0];
    endfunction
endpackage

// File: rtl/irqt_regs.sv
`timescale 1ns/1ps
// Register window of the timer. It decodes full-width accesses only: any
// access without all byte enables is dropped and reads zero. The current
// count comes from the counter and is read-only here.
module irqt_regs
    import irqt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  cur_count,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [VEC_W-1:0]  tpr,
    output logic              sw_en,
    output logic [VEC_W-1:0]  spur_vec,
    output logic [VEC_W-1:0]  lvt_vec,
    output logic              lvt_mask,
    output logic              lvt_periodic,
    output logic [BUS_W-1:0]  icr,
    output logic [CODE_W-1:0] div_code,
    output logic              icr_wr
);
    logic full_acc;
    logic wr_ok;

    // Qualify an access: every byte lane must be enabled.
    always_comb begin
        full_acc = &bus_be;
        wr_ok    = bus_wr && full_acc;
        icr_wr   = wr_ok && (bus_addr == OFF_ICR);
    end

    // Store writable fields; the vector entry comes out of reset masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr          <= '0;
            sw_en        <= 1'b0;
            spur_vec     <= '0;
            lvt_vec      <= '0;
            lvt_mask     <= 1'b1;
            lvt_periodic <= 1'b0;
            icr          <= '0;
            div_code     <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                OFF_TPR: tpr <= bus_wdata[7:0];
                OFF_SVR: begin
                    spur_vec <= bus_wdata[7:0];
                    sw_en    <= bus_wdata[8];
                end
                OFF_LVT: begin
                    lvt_vec      <= bus_wdata[7:0];
                    lvt_mask     <= bus_wdata[16];
                    lvt_periodic <= bus_wdata[17];
                end
                OFF_ICR: icr <= bus_wdata;
                OFF_DCR: div_code <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
                default: ;
            endcase
        end
    end

    // Return read data for a full-width read, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && full_acc) begin
            case (bus_addr)
                OFF_TPR: bus_rdata = {24'd0, tpr};
                OFF_SVR: bus_rdata = {23'd0, sw_en, spur_vec};
                OFF_LVT: bus_rdata = {14'd0, lvt_periodic, lvt_mask, 8'd0, lvt_vec};
                OFF_ICR: bus_rdata = icr;
                OFF_CCR: bus_rdata = cur_count;
                OFF_DCR: bus_rdata = {28'd0, div_code[2], 1'b0, div_code[1:0]};
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqt_prescale.sv
`timescale 1ns/1ps
// Prescaler: emits a one-cycle tick every D clocks while the timer runs.
// It assumes a restart pulse on every count load, which realigns the phase
// so that the first tick comes D cycles after the load.
module irqt_prescale
    import irqt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [CODE_W-1:0] div_code,
    output logic              tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] limit;

    // Terminal value for the selected ratio; >= copes with a ratio shrinking mid-run.
    always_comb begin
        limit = ratio_m1(div_code);
        tick  = run && (pcnt >= limit);
    end

    // Phase counter, cleared on load, while idle and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pcnt <= '0;
        else if (restart || !run || tick) pcnt <= '0;
        else                              pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/irqt_counter.sv
`timescale 1ns/1ps
// Countdown core: it loads on an initial-count write and steps down once
// per prescaler tick. At the end of a count it sets the pending flag, and
// then it reloads (periodic) or stops at zero (one-shot). The acknowledge
// clears the pending flag; a new event in the same cycle wins.
module irqt_counter
    import irqt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] load_val,
    input  logic [BUS_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             tick,
    input  logic             ack,
    output logic [BUS_W-1:0] count,
    output logic             running,
    output logic             pending
);
    logic expire;

    // An event happens on the tick that would take the count from one to zero.
    always_comb expire = !load && running && tick && (count == BUS_W'(1));

    // Count register and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (load) begin
            count   <= load_val;
            running <= (load_val != '0);
        end else if (expire) begin
            if (periodic) begin
                count <= reload_val;
            end else begin
                count   <= '0;
                running <= 1'b0;
            end
        end else if (running && tick) begin
            count <= count - 1'b1;
        end
    end

    // Pending flag: set by an event, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (expire) pending <= 1'b1;
        else if (ack)    pending <= 1'b0;
    end
endmodule

// File: rtl/irq_countdown_timer.sv
`timescale 1ns/1ps
// Top of the register-mapped interrupt timer. It joins the register window,
// the prescaler and the countdown core, and applies the three delivery
// gates (software enable, mask, priority threshold) to the pending flag.
module irq_countdown_timer
    import irqt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    logic [VEC_W-1:0]  tpr;
    logic              sw_en;
    logic [VEC_W-1:0]  spur_vec;
    logic [VEC_W-1:0]  lvt_vec;
    logic              lvt_mask;
    logic              lvt_periodic;
    logic [BUS_W-1:0]  icr;
    logic [CODE_W-1:0] div_code;
    logic              icr_wr;
    logic [BUS_W-1:0]  cur_count;
    logic              running;
    logic              pending;
    logic              tick;

    irqt_regs i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .cur_count(cur_count), .bus_rdata(bus_rdata), .tpr(tpr),
        .sw_en(sw_en), .spur_vec(spur_vec), .lvt_vec(lvt_vec),
        .lvt_mask(lvt_mask), .lvt_periodic(lvt_periodic), .icr(icr),
        .div_code(div_code), .icr_wr(icr_wr)
    );

    irqt_prescale i_pre (
        .clk(clk), .rst_n(rst_n), .restart(icr_wr), .run(running),
        .div_code(div_code), .tick(tick)
    );

    irqt_counter i_cnt (
        .clk(clk), .rst_n(rst_n), .load(icr_wr), .load_val(bus_wdata),
        .reload_val(icr), .periodic(lvt_periodic), .tick(tick),
        .ack(irq_ack), .count(cur_count), .running(running),
        .pending(pending)
    );

    // Deliver a pending event only through all three open gates.
    always_comb begin
        irq_vec = lvt_vec;
        irq_req = pending && sw_en && !lvt_mask && (tpr <= lvt_vec);
    end
endmodule

// File: rtl/irqt_checker.sv
`timescale 1ns/1ps
// Property checker for the interrupt timer, attached to the top by bind.
// It relates bus traffic, the gates and the pending flag over time.
module irqt_checker
    import irqt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BE_W-1:0]   bus_be,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq_ack,
    input logic              irq_req,
    input logic              sw_en,
    input logic              lvt_mask,
    input logic [VEC_W-1:0]  lvt_vec,
    input logic [VEC_W-1:0]  tpr,
    input logic              pending,
    input logic [BUS_W-1:0]  icr,
    input logic [CODE_W-1:0] div_code,
    input logic [BUS_W-1:0]  cur_count
);
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> !irq_req);
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lvt_mask |-> !irq_req);
    a_r8_priority_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (tpr <= lvt_vec));
    a_r9_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_be != 4'hF)) |=> ($stable(tpr) && $stable(sw_en) &&
        $stable(lvt_vec) && $stable(lvt_mask) && $stable(icr) && $stable(div_code)));
    a_r9_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_be != 4'hF)) |-> (bus_rdata == '0));
    a_r10_clear_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(irq_ack));
    a_r11_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_be == 4'hF) && (bus_addr == OFF_ICR) && (bus_wdata == '0))
        |=> (cur_count == '0));
    a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_count == '0) && !(bus_wr && (bus_addr == OFF_ICR)))
        |=> (cur_count == '0));
endmodule

bind irq_countdown_timer irqt_checker i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq_req(irq_req),
    .sw_en(sw_en), .lvt_mask(lvt_mask), .lvt_vec(lvt_vec), .tpr(tpr),
    .pending(pending), .icr(icr), .div_code(div_code), .cur_count(cur_count)
);

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
// Self-checking bench: seeded random countdown timing plus directed gate,
// bus-width and stop cases, with expected values from bench functions.
module test_irq_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int t0 = 0;
    bit done = 0;

    irq_countdown_timer i_irq_countdown_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_vec(irq_vec)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected end before 190000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Prescale ratio for a 3-bit divide code (R3 table).
    function automatic int exp_ratio(input int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        t0 = cyc;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0; bus_be = '0;
    endtask

    task automatic wait_req(input int limit, output int k);
        k = cyc - t0;
        while (!irq_req && k < limit) begin
            @(posedge clk);
            @(negedge clk);
            k = cyc - t0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        int k;
        void'($urandom(32'd2024));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(12'h080, 4'hF, d); check(d == 0, "R1 tpr reset", d, 0);
        rd(12'h0F0, 4'hF, d); check(d == 0, "R1 svr reset", d, 0);
        rd(12'h320, 4'hF, d); check(d == 32'h0001_0000, "R1 lvt reset", d, 32'h0001_0000);
        rd(12'h380, 4'hF, d); check(d == 0, "R1 icr reset", d, 0);
        rd(12'h390, 4'hF, d); check(d == 0, "R1 ccr reset", d, 0);
        rd(12'h3E0, 4'hF, d); check(d == 0, "R1 dcr reset", d, 0);
        check(irq_req == 0, "R1 req low", irq_req, 0);

        // R2 field readback
        wr(12'h320, 32'hFFFF_FFFF, 4'hF);
        rd(12'h320, 4'hF, d); check(d == 32'h0003_00FF, "R2 lvt fields", d, 32'h0003_00FF);
        wr(12'h3E0, 32'h0000_000F, 4'hF);
        rd(12'h3E0, 4'hF, d); check(d == 32'hB, "R2 dcr bit2 reads 0", d, 32'hB);
        wr(12'h390, 32'h1234, 4'hF);
        rd(12'h390, 4'hF, d); check(d == 0, "R2 ccr read-only", d, 0);
        rd(12'h100, 4'hF, d); check(d == 0, "R2 unmapped zero", d, 0);

        // R9 narrow accesses
        wr(12'h080, 32'h12, 4'hF);
        wr(12'h080, 32'hFF, 4'b0111);
        rd(12'h080, 4'hF, d); check(d == 32'h12, "R9 narrow write ignored", d, 32'h12);
        rd(12'h080, 4'b1110, d); check(d == 0, "R9 narrow read zero", d, 0);

        // R3/R4 random one-shot timing
        wr(12'h080, 32'h0, 4'hF);
        wr(12'h0F0, 32'h1FF, 4'hF);
        for (int it = 0; it < 10; it++) begin
            int code = $urandom_range(0, 7);
            int n = $urandom_range(1, 20);
            int b2 = $urandom_range(0, 1);
            logic [7:0] v = 8'($urandom_range(16, 255));
            int exp = n * exp_ratio(code);
            wr(12'h320, {24'd0, v}, 4'hF);
            wr(12'h3E0, {28'd0, code[2], b2[0], code[1], code[0]}, 4'hF);
            wr(12'h380, n, 4'hF);
            wait_req(exp + 10, k);
            check(k == exp, "R3 event cycle", k, exp);
            check(irq_vec == v, "R12 vector", irq_vec, v);
            rd(12'h390, 4'hF, d); check(d == 0, "R4 count at zero", d, 0);
            ack();
            check(irq_req == 0, "R10 ack clears", irq_req, 0);
            idle(exp + 3);
            check(irq_req == 0, "R4 no refire", irq_req, 0);
        end

        // R5 periodic interval
        wr(12'h3E0, 32'hB, 4'hF);
        wr(12'h320, 32'h0002_0033, 4'hF);
        wr(12'h380, 5, 4'hF);
        for (int e = 1; e <= 3; e++) begin
            wait_req(5 * e + 10, k);
            check(k == 5 * e, "R5 periodic event", k, 5 * e);
            ack();
        end
        wr(12'h380, 0, 4'hF);
        idle(2);
        ack();

        // R7 mask holds pending
        wr(12'h320, 32'h0001_0040, 4'hF);
        wr(12'h380, 3, 4'hF);
        idle(6);
        check(irq_req == 0, "R7 masked quiet", irq_req, 0);
        wr(12'h320, 32'h0000_0040, 4'hF);
        check(irq_req == 1, "R7 held then delivered", irq_req, 1);
        ack();

        // R6 enable gate
        wr(12'h0F0, 32'h0, 4'hF);
        wr(12'h0F0, 32'h1FF, 4'b0001);
        rd(12'h0F0, 4'hF, d); check(d == 0, "R6 low byte no enable", d, 0);
        wr(12'h380, 3, 4'hF);
        idle(6);
        check(irq_req == 0, "R6 disabled quiet", irq_req, 0);
        wr(12'h0F0, 32'h100, 4'hF);
        check(irq_req == 1, "R6 delivered on enable", irq_req, 1);
        ack();

        // R8 priority threshold
        wr(12'h080, 32'h41, 4'hF);
        wr(12'h380, 3, 4'hF);
        idle(6);
        check(irq_req == 0, "R8 threshold above vector", irq_req, 0);
        wr(12'h080, 32'h40, 4'hF);
        check(irq_req == 1, "R8 threshold equal passes", irq_req, 1);
        check(irq_vec == 8'h40, "R12 vector out", irq_vec, 8'h40);
        ack();

        // R11 zero stops
        wr(12'h380, 1000, 4'hF);
        idle(10);
        wr(12'h380, 0, 4'hF);
        rd(12'h390, 4'hF, d); check(d == 0, "R11 count reads zero", d, 0);
        idle(1100);
        check(irq_req == 0, "R11 no event after stop", irq_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule